// File: doc/BRIEF.md
# Far call protection checker

This block judges one far procedure call made in protected mode (outside virtual-8086 mode). The caller hands it the target selector and offset, the already fetched fields of the target descriptor, the descriptor-table limit, the current privilege level, the operand size, the free stack space, the code segment limit, the current CS and instruction pointer, and a trap-on-branch flag. After a start strobe the block returns a verdict. The verdict is either a single fault with its error code, or, for a code segment target, the two return-address words to push and the CS and EIP to load.

The checks run in a fixed order: null selector, table limit, descriptor type, privilege, presence, stack room, and last the code segment limit. The first check that fails decides the fault. Gate and task-state targets are only classified and reported; switching through them is left to the logic around this block. The block does not fetch descriptors and does not write the stack.

Top module: `farcall_check`

## Requirements
- R1: One cycle after a clock edge with `start` high, `done` is high for exactly one cycle and all results are valid. Without `start`, `done` stays low. `fault_vec`, `push_valid`, `load_valid` and `dbg_trap` are only high together with `done`.
- R2: A selector whose bits 15:2 are all zero is null. It raises a general-protection fault with error code 0, and no other check can override it.
- R3: If `{sel[15:3],3'b111}` exceeds `tbl_limit`, a general-protection fault is raised with error code `sel & 16'hFFFC`, and `call_class` is 0.
- R4: Classification, where `desc_s`=1 means code/data: code with type bit 3 set is conforming (class 1) when type bit 2 is set and nonconforming (class 2) otherwise. For system descriptors, type 4 or 12 is a call gate (3), type 5 is a task gate (4), and types 1, 3, 9 and 11 are a TSS (5). Every other type gives a general-protection fault with code `sel & 16'hFFFC` and class 0.
- R5: For a conforming target, DPL greater than CPL gives a general-protection fault with code `sel & 16'hFFFC`.
- R6: For a nonconforming target, RPL greater than CPL, or DPL different from CPL, gives a general-protection fault with code `sel & 16'hFFFC`.
- R7: A code target whose present bit is clear gives a not-present fault with code `sel & 16'hFFFC`. This check comes only after the privilege check.
- R8: After the presence check, free stack below 6 bytes (32-bit operand size) or below 4 bytes (16-bit operand size) gives a stack fault with code 0.
- R9: After the stack check, a new EIP greater than `cs_limit` gives a general-protection fault with code 0.
- R10: On a successful code-segment call, `push_valid` is high. `push_first` holds the current CS zero-extended. `push_second` holds the current EIP (32-bit) or its low 16 bits zero-extended (16-bit).
- R11: On success, `load_valid` is high. `new_cs` is the target selector with bits 1:0 replaced by CPL. `new_eip` is the offset, with its upper 16 bits cleared for 16-bit operand size.
- R12: `fault_vec` is one-hot or zero, with bit 2 = stack, bit 1 = not-present and bit 0 = general protection. When a fault is reported, there is no push, no load and no debug trap.
- R13: With `trap_branch` set, a successful code-segment call pulses `dbg_trap` together with `done`.
- R14: Call gate, task gate and TSS targets report their class without a fault, push or load, whatever their DPL, present bit, stack or offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Evaluate the presented call |
| tgt_sel | input | 16 | Target selector |
| tgt_off | input | ADDR_W | Target offset |
| desc_s | input | 1 | Descriptor kind: 1 code/data, 0 system |
| desc_type | input | 4 | Descriptor type field |
| desc_dpl | input | 2 | Descriptor privilege level |
| desc_present | input | 1 | Descriptor present bit |
| tbl_limit | input | 16 | Descriptor-table limit in bytes |
| cpl | input | 2 | Current privilege level |
| op32 | input | 1 | 1 = 32-bit operand size, 0 = 16-bit |
| stack_free | input | STK_W | Free stack bytes |
| cs_limit | input | ADDR_W | Target code segment limit |
| cur_cs | input | 16 | Current CS selector |
| cur_eip | input | ADDR_W | Return instruction pointer |
| trap_branch | input | 1 | Trap-on-branch debug flag |
| done | output | 1 | Result valid pulse |
| fault_vec | output | 3 | One-hot fault {stack, not-present, general protection} |
| err_code | output | 16 | Error code of the reported fault |
| call_class | output | 3 | Dispatch class, 0 when none |
| push_valid | output | 1 | Return frame to push |
| push_first | output | ADDR_W | First pushed word (CS) |
| push_second | output | ADDR_W | Second pushed word (IP) |
| load_valid | output | 1 | Load new CS and EIP |
| new_cs | output | 16 | New CS selector |
| new_eip | output | ADDR_W | New instruction pointer |
| dbg_trap | output | 1 | Debug exception after a successful call |

## Verification
The bench builds the block with its defaults, ADDR_W = 32 and STK_W = 16. The 32-bit address width means a 16-bit call can carry offsets and return pointers with nonzero upper halves, so the masking of the new EIP and of the pushed IP is actually tested. The 16-bit stack counter lets the bench place free space exactly at and one below the 4- and 6-byte thresholds. The stimuli stack several failing conditions on one call to test the priority order, and they issue starts back to back.

// File: rtl/farcall_pkg.sv
package farcall_pkg;

    localparam int SEL_W          = 16;
    localparam int FRAME32_BYTES  = 6;
    localparam int FRAME16_BYTES  = 4;

    typedef enum logic [2:0] {
        CLS_NONE    = 3'd0,
        CLS_CONF    = 3'd1,
        CLS_NONCONF = 3'd2,
        CLS_CALLG   = 3'd3,
        CLS_TASKG   = 3'd4,
        CLS_TSS     = 3'd5
    } call_class_e;

    typedef struct packed {
        logic ss;
        logic np;
        logic gp;
    } fault_t;

    typedef struct packed {
        fault_t           f;
        logic [SEL_W-1:0] err;
    } verdict_t;

    localparam verdict_t VD_OK = '{f: 3'b000, err: 16'h0000};

    function automatic call_class_e decode_class(input logic is_code_data,
                                                 input logic [3:0] t);
        call_class_e c;
        c = CLS_NONE;
        if (is_code_data) begin
            if (t[3]) c = t[2] ? CLS_CONF : CLS_NONCONF;
        end else begin
            case (t)
                4'h4, 4'hC:               c = CLS_CALLG;
                4'h5:                     c = CLS_TASKG;
                4'h1, 4'h3, 4'h9, 4'hB:   c = CLS_TSS;
                default:                  c = CLS_NONE;
            endcase
        end
        return c;
    endfunction

    function automatic logic is_code(input call_class_e c);
        return (c == CLS_CONF) || (c == CLS_NONCONF);
    endfunction

    function automatic verdict_t gp_with(input logic [SEL_W-1:0] code);
        verdict_t v;
        v.f   = '{ss: 1'b0, np: 1'b0, gp: 1'b1};
        v.err = code;
        return v;
    endfunction

endpackage

// File: rtl/farcall_classify.sv
module farcall_classify
    import farcall_pkg::*;
(
    input  logic [13:0] sel_hi,
    input  logic [15:0] tbl_limit,
    input  logic        desc_s,
    input  logic [3:0]  desc_type,
    output call_class_e cls,
    output verdict_t    vd
);
    logic              is_null;
    logic [15:0]       last_byte;
    logic              over_limit;
    call_class_e       raw_cls;
    logic [SEL_W-1:0]  sel_err;

    assign is_null    = (sel_hi == 14'd0);
    assign last_byte  = {sel_hi[13:1], 3'b111};
    assign over_limit = (last_byte > tbl_limit);
    assign raw_cls    = decode_class(desc_s, desc_type);
    assign sel_err    = {sel_hi, 2'b00};

    always_comb begin
        cls = CLS_NONE;
        vd  = VD_OK;
        if (is_null) begin
            vd = gp_with(16'h0000);
        end else if (over_limit) begin
            vd = gp_with(sel_err);
        end else if (raw_cls == CLS_NONE) begin
            vd = gp_with(sel_err);
        end else begin
            cls = raw_cls;
        end
    end
endmodule

// File: rtl/farcall_priv.sv
module farcall_priv
    import farcall_pkg::*;
(
    input  call_class_e cls,
    input  logic [13:0] sel_hi,
    input  logic [1:0]  rpl,
    input  logic [1:0]  dpl,
    input  logic [1:0]  cpl,
    input  logic        present,
    output verdict_t    vd
);
    logic             priv_bad;
    logic [SEL_W-1:0] sel_err;

    assign sel_err = {sel_hi, 2'b00};

    always_comb begin
        case (cls)
            CLS_CONF:    priv_bad = (dpl > cpl);
            CLS_NONCONF: priv_bad = (rpl > cpl) || (dpl != cpl);
            default:     priv_bad = 1'b0;
        endcase
    end

    always_comb begin
        vd = VD_OK;
        if (is_code(cls)) begin
            if (priv_bad) begin
                vd = gp_with(sel_err);
            end else if (!present) begin
                vd.f   = '{ss: 1'b0, np: 1'b1, gp: 1'b0};
                vd.err = sel_err;
            end
        end
    end
endmodule

// File: rtl/farcall_frame.sv
module farcall_frame
    import farcall_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int STK_W  = 16
) (
    input  logic              op32,
    input  logic [STK_W-1:0]  stack_free,
    input  logic [ADDR_W-1:0] cs_limit,
    input  logic [ADDR_W-1:0] tgt_off,
    input  logic [ADDR_W-1:0] cur_eip,
    input  logic [15:0]       cur_cs,
    input  logic [13:0]       sel_hi,
    input  logic [1:0]        cpl,
    output verdict_t          vd,
    output logic [ADDR_W-1:0] word_cs,
    output logic [ADDR_W-1:0] word_ip,
    output logic [ADDR_W-1:0] next_eip,
    output logic [15:0]       next_cs
);
    localparam logic [STK_W-1:0] NEED32 = STK_W'(FRAME32_BYTES);
    localparam logic [STK_W-1:0] NEED16 = STK_W'(FRAME16_BYTES);

    logic [ADDR_W-1:0] off16;
    logic [ADDR_W-1:0] ip16;
    logic              stack_short;
    logic              beyond_limit;

    generate
        if (ADDR_W > 16) begin : g_wide
            assign off16   = {{(ADDR_W-16){1'b0}}, tgt_off[15:0]};
            assign ip16    = {{(ADDR_W-16){1'b0}}, cur_eip[15:0]};
            assign word_cs = {{(ADDR_W-16){1'b0}}, cur_cs};
        end else begin : g_narrow
            assign off16   = tgt_off;
            assign ip16    = cur_eip;
            assign word_cs = cur_cs;
        end
    endgenerate

    assign next_eip     = op32 ? tgt_off : off16;
    assign word_ip      = op32 ? cur_eip : ip16;
    assign next_cs      = {sel_hi, cpl};
    assign stack_short  = stack_free < (op32 ? NEED32 : NEED16);
    assign beyond_limit = next_eip > cs_limit;

    always_comb begin
        vd = VD_OK;
        if (stack_short) begin
            vd.f   = '{ss: 1'b1, np: 1'b0, gp: 1'b0};
            vd.err = 16'h0000;
        end else if (beyond_limit) begin
            vd = gp_with(16'h0000);
        end
    end
endmodule

// File: rtl/farcall_check.sv
module farcall_check
    import farcall_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int STK_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [15:0]       tgt_sel,
    input  logic [ADDR_W-1:0] tgt_off,
    input  logic              desc_s,
    input  logic [3:0]        desc_type,
    input  logic [1:0]        desc_dpl,
    input  logic              desc_present,
    input  logic [15:0]       tbl_limit,
    input  logic [1:0]        cpl,
    input  logic              op32,
    input  logic [STK_W-1:0]  stack_free,
    input  logic [ADDR_W-1:0] cs_limit,
    input  logic [15:0]       cur_cs,
    input  logic [ADDR_W-1:0] cur_eip,
    input  logic              trap_branch,
    output logic              done,
    output logic [2:0]        fault_vec,
    output logic [15:0]       err_code,
    output logic [2:0]        call_class,
    output logic              push_valid,
    output logic [ADDR_W-1:0] push_first,
    output logic [ADDR_W-1:0] push_second,
    output logic              load_valid,
    output logic [15:0]       new_cs,
    output logic [ADDR_W-1:0] new_eip,
    output logic              dbg_trap
);
    call_class_e       cls;
    verdict_t          vd_sel, vd_priv, vd_frame, vd_final;
    logic [ADDR_W-1:0] w_cs, w_ip, n_eip;
    logic [15:0]       n_cs;
    logic              success;

    farcall_classify u_classify (
        .sel_hi    (tgt_sel[15:2]),
        .tbl_limit (tbl_limit),
        .desc_s    (desc_s),
        .desc_type (desc_type),
        .cls       (cls),
        .vd        (vd_sel)
    );

    farcall_priv u_priv (
        .cls     (cls),
        .sel_hi  (tgt_sel[15:2]),
        .rpl     (tgt_sel[1:0]),
        .dpl     (desc_dpl),
        .cpl     (cpl),
        .present (desc_present),
        .vd      (vd_priv)
    );

    farcall_frame #(.ADDR_W(ADDR_W), .STK_W(STK_W)) u_frame (
        .op32       (op32),
        .stack_free (stack_free),
        .cs_limit   (cs_limit),
        .tgt_off    (tgt_off),
        .cur_eip    (cur_eip),
        .cur_cs     (cur_cs),
        .sel_hi     (tgt_sel[15:2]),
        .cpl        (cpl),
        .vd         (vd_frame),
        .word_cs    (w_cs),
        .word_ip    (w_ip),
        .next_eip   (n_eip),
        .next_cs    (n_cs)
    );

    always_comb begin
        vd_final = VD_OK;
        success  = 1'b0;
        if (vd_sel.f != 3'b000) begin
            vd_final = vd_sel;
        end else if (is_code(cls)) begin
            if (vd_priv.f != 3'b000)       vd_final = vd_priv;
            else if (vd_frame.f != 3'b000) vd_final = vd_frame;
            else                           success  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done        <= 1'b0;
            fault_vec   <= 3'b000;
            err_code    <= 16'h0000;
            call_class  <= CLS_NONE;
            push_valid  <= 1'b0;
            push_first  <= '0;
            push_second <= '0;
            load_valid  <= 1'b0;
            new_cs      <= 16'h0000;
            new_eip     <= '0;
            dbg_trap    <= 1'b0;
        end else if (start) begin
            done        <= 1'b1;
            fault_vec   <= vd_final.f;
            err_code    <= vd_final.err;
            call_class  <= cls;
            push_valid  <= success;
            push_first  <= w_cs;
            push_second <= w_ip;
            load_valid  <= success;
            new_cs      <= n_cs;
            new_eip     <= n_eip;
            dbg_trap    <= success && trap_branch;
        end else begin
            done       <= 1'b0;
            fault_vec  <= 3'b000;
            push_valid <= 1'b0;
            load_valid <= 1'b0;
            dbg_trap   <= 1'b0;
        end
    end
endmodule

// File: rtl/farcall_check_sva.sv
module farcall_check_sva #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic [15:0]       tgt_sel,
    input logic [1:0]        cpl,
    input logic              op32,
    input logic              done,
    input logic [2:0]        fault_vec,
    input logic [15:0]       err_code,
    input logic              push_valid,
    input logic              load_valid,
    input logic [15:0]       new_cs,
    input logic [ADDR_W-1:0] new_eip,
    input logic              dbg_trap
);
    p_done_after_start_r1: assert property (@(posedge clk) disable iff (rst)
        start |=> done);

    p_done_idle_r1: assert property (@(posedge clk) disable iff (rst)
        !start |=> !done);

    p_null_first_r2: assert property (@(posedge clk) disable iff (rst)
        (start && tgt_sel[15:2] == 14'd0) |=> (fault_vec == 3'b001 && err_code == 16'h0000));

    p_fault_onehot_r12: assert property (@(posedge clk) disable iff (rst)
        $onehot0(fault_vec));

    p_fault_quiet_r12: assert property (@(posedge clk) disable iff (rst)
        (fault_vec != 3'b000) |-> (!push_valid && !load_valid && !dbg_trap));

    p_push_with_load_r10: assert property (@(posedge clk) disable iff (rst)
        push_valid |-> load_valid);

    p_rpl_from_cpl_r11: assert property (@(posedge clk) disable iff (rst)
        load_valid |-> new_cs[1:0] == $past(cpl));

    p_ip16_masked_r11: assert property (@(posedge clk) disable iff (rst)
        (load_valid && !$past(op32)) |-> ((new_eip >> 16) == '0));

    p_trap_on_success_r13: assert property (@(posedge clk) disable iff (rst)
        dbg_trap |-> (load_valid && done));
endmodule

bind farcall_check farcall_check_sva #(.ADDR_W(ADDR_W)) u_sva (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .tgt_sel    (tgt_sel),
    .cpl        (cpl),
    .op32       (op32),
    .done       (done),
    .fault_vec  (fault_vec),
    .err_code   (err_code),
    .push_valid (push_valid),
    .load_valid (load_valid),
    .new_cs     (new_cs),
    .new_eip    (new_eip),
    .dbg_trap   (dbg_trap)
);

// File: tb/farcall_check_tb.sv
`timescale 1ns/1ps
module farcall_check_tb;
    localparam int AW = 32;
    localparam int SW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [15:0]   tgt_sel = '0;
    logic [AW-1:0] tgt_off = '0;
    logic          desc_s = 1'b0;
    logic [3:0]    desc_type = '0;
    logic [1:0]    desc_dpl = '0;
    logic          desc_present = 1'b0;
    logic [15:0]   tbl_limit = '0;
    logic [1:0]    cpl = '0;
    logic          op32 = 1'b0;
    logic [SW-1:0] stack_free = '0;
    logic [AW-1:0] cs_limit = '0;
    logic [15:0]   cur_cs = '0;
    logic [AW-1:0] cur_eip = '0;
    logic          trap_branch = 1'b0;
    logic          done;
    logic [2:0]    fault_vec;
    logic [15:0]   err_code;
    logic [2:0]    call_class;
    logic          push_valid;
    logic [AW-1:0] push_first, push_second;
    logic          load_valid;
    logic [15:0]   new_cs;
    logic [AW-1:0] new_eip;
    logic          dbg_trap;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    farcall_check #(.ADDR_W(AW), .STK_W(SW)) u_dut (.*);

    typedef struct {
        logic [15:0]   sel;
        logic [AW-1:0] off;
        logic          s;
        logic [3:0]    typ;
        logic [1:0]    dpl;
        logic          pres;
        logic [15:0]   lim;
        logic [1:0]    cpl;
        logic          op32;
        logic [SW-1:0] sfree;
        logic [AW-1:0] cslim;
        logic [15:0]   ccs;
        logic [AW-1:0] ceip;
        logic          trap;
        string         tag;
    } stim_t;

    typedef struct {
        logic [2:0]    fault;
        logic [15:0]   err;
        logic [2:0]    cls;
        logic          ok;
        logic [AW-1:0] w1, w2, eip;
        logic [15:0]   cs;
        logic          trap;
        string         tag;
    } exp_t;

    exp_t q[$];

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic stim_t base(input string tag);
        stim_t s;
        s.sel = 16'h0010; s.off = 32'h0000_1000; s.s = 1'b1; s.typ = 4'hA;
        s.dpl = 2'd0; s.pres = 1'b1; s.lim = 16'h00FF; s.cpl = 2'd0;
        s.op32 = 1'b1; s.sfree = 16'd100; s.cslim = 32'h0000_FFFF;
        s.ccs = 16'h0008; s.ceip = 32'hABCD_2345; s.trap = 1'b0; s.tag = tag;
        return s;
    endfunction

    function automatic exp_t model(input stim_t s);
        exp_t e;
        logic [2:0] c;
        logic [AW-1:0] ne;
        int need;
        e.fault = 3'b000; e.err = 16'h0; e.cls = 3'd0; e.ok = 1'b0;
        e.w1 = '0; e.w2 = '0; e.eip = '0; e.cs = '0; e.trap = 1'b0; e.tag = s.tag;
        if (s.sel[15:2] == 14'd0) begin e.fault = 3'b001; return e; end
        if ({s.sel[15:3], 3'b111} > s.lim) begin
            e.fault = 3'b001; e.err = s.sel & 16'hFFFC; return e;
        end
        c = 3'd0;
        if (s.s) begin
            if (s.typ[3]) c = s.typ[2] ? 3'd1 : 3'd2;
        end else if (s.typ == 4'h4 || s.typ == 4'hC) c = 3'd3;
        else if (s.typ == 4'h5) c = 3'd4;
        else if (s.typ == 4'h1 || s.typ == 4'h3 || s.typ == 4'h9 || s.typ == 4'hB) c = 3'd5;
        if (c == 3'd0) begin e.fault = 3'b001; e.err = s.sel & 16'hFFFC; return e; end
        e.cls = c;
        if (c > 3'd2) return e;
        if ((c == 3'd1 && s.dpl > s.cpl) ||
            (c == 3'd2 && (s.sel[1:0] > s.cpl || s.dpl != s.cpl))) begin
            e.fault = 3'b001; e.err = s.sel & 16'hFFFC; return e;
        end
        if (!s.pres) begin e.fault = 3'b010; e.err = s.sel & 16'hFFFC; return e; end
        need = s.op32 ? 6 : 4;
        if (int'(s.sfree) < need) begin e.fault = 3'b100; return e; end
        ne = s.op32 ? s.off : (s.off & 32'h0000_FFFF);
        if (ne > s.cslim) begin e.fault = 3'b001; return e; end
        e.ok = 1'b1; e.eip = ne; e.cs = {s.sel[15:2], s.cpl};
        e.w1 = {16'h0, s.ccs};
        e.w2 = s.op32 ? s.ceip : (s.ceip & 32'h0000_FFFF);
        e.trap = s.trap;
        return e;
    endfunction

    task automatic send(input stim_t s);
        @(negedge clk);
        tgt_sel = s.sel; tgt_off = s.off; desc_s = s.s; desc_type = s.typ;
        desc_dpl = s.dpl; desc_present = s.pres; tbl_limit = s.lim; cpl = s.cpl;
        op32 = s.op32; stack_free = s.sfree; cs_limit = s.cslim;
        cur_cs = s.ccs; cur_eip = s.ceip; trap_branch = s.trap;
        q.push_back(model(s));
        start = 1'b1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            start = 1'b0;
        end
    endtask

    // Monitor: compare each result against the scoreboard head
    always @(negedge clk) begin
        if (!rst) begin
            if (done) begin
                if (q.size() == 0) begin
                    chk("R1", "unexpected done", 64'd1, 64'd0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk(e.tag, "fault_vec", 64'(fault_vec), 64'(e.fault));
                    chk(e.tag, "err_code", 64'(err_code), 64'(e.err));
                    chk(e.tag, "call_class", 64'(call_class), 64'(e.cls));
                    chk(e.tag, "push_valid", 64'(push_valid), 64'(e.ok));
                    chk(e.tag, "load_valid", 64'(load_valid), 64'(e.ok));
                    chk(e.tag, "dbg_trap", 64'(dbg_trap), 64'(e.trap));
                    if (e.ok) begin
                        chk(e.tag, "push_first", 64'(push_first), 64'(e.w1));
                        chk(e.tag, "push_second", 64'(push_second), 64'(e.w2));
                        chk(e.tag, "new_cs", 64'(new_cs), 64'(e.cs));
                        chk(e.tag, "new_eip", 64'(new_eip), 64'(e.eip));
                    end
                end
            end else begin
                if (fault_vec != 3'b000 || push_valid || load_valid || dbg_trap)
                    chk("R1", "flags without done", 64'd1, 64'd0);
            end
        end
    end

    task automatic run_all();
        stim_t s;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "reset done", 64'(done), 64'd0);
        chk("R1", "reset fault_vec", 64'(fault_vec), 64'd0);
        chk("R1", "reset push/load", 64'({push_valid, load_valid}), 64'd0);

        // R2: null selector beats a bad type and a bad limit
        s = base("R2 null"); s.sel = 16'h0003; s.s = 1'b0; s.typ = 4'h0; s.lim = 16'h0;
        send(s); idle(1);
        // R3: index beyond table limit
        s = base("R3 limit"); s.sel = 16'h0102; send(s); idle(1);
        s = base("R3 edge ok"); s.sel = 16'h00F8; s.lim = 16'h00FF; send(s); idle(1);
        // R4: bad types
        s = base("R4 data seg"); s.typ = 4'h2; send(s); idle(1);
        s = base("R4 sys bad"); s.s = 1'b0; s.typ = 4'h2; send(s); idle(1);
        // R5: conforming
        s = base("R5 dpl>cpl"); s.typ = 4'hE; s.dpl = 2'd3; s.cpl = 2'd1; s.sel = 16'h0011; send(s);
        s = base("R5 dpl<cpl ok"); s.typ = 4'hE; s.dpl = 2'd0; s.cpl = 2'd2; s.sel = 16'h0013; send(s);
        idle(1);
        // R6: nonconforming
        s = base("R6 rpl>cpl"); s.sel = 16'h0013; s.dpl = 2'd1; s.cpl = 2'd1; send(s);
        s = base("R6 dpl!=cpl"); s.sel = 16'h0011; s.dpl = 2'd0; s.cpl = 2'd1; send(s);
        s = base("R6 equal ok"); s.sel = 16'h0011; s.dpl = 2'd1; s.cpl = 2'd1; send(s);
        idle(1);
        // R7: not present, and ordering after privilege
        s = base("R7 np"); s.pres = 1'b0; send(s); idle(1);
        s = base("R7 priv first"); s.pres = 1'b0; s.dpl = 2'd2; send(s); idle(1);
        // R8: stack thresholds
        s = base("R8 32 short"); s.sfree = 16'd5; send(s);
        s = base("R8 32 exact"); s.sfree = 16'd6; send(s);
        s = base("R8 16 short"); s.op32 = 1'b0; s.sfree = 16'd3; send(s);
        s = base("R8 16 exact"); s.op32 = 1'b0; s.sfree = 16'd4; send(s);
        idle(1);
        // R9: code limit, and stack before limit
        s = base("R9 beyond"); s.off = 32'h0001_0000; send(s); idle(1);
        s = base("R9 at limit"); s.off = 32'h0000_FFFF; send(s); idle(1);
        s = base("R9 stack first"); s.off = 32'h0001_0000; s.sfree = 16'd2; send(s); idle(1);
        // R10 R11: 16-bit masking of new EIP and pushed IP
        s = base("R11 mask16"); s.op32 = 1'b0; s.off = 32'h0001_2345; s.cslim = 32'h0000_3000;
        s.cpl = 2'd2; s.dpl = 2'd2; s.sel = 16'h0022; send(s); idle(1);
        s = base("R10 push32"); s.ceip = 32'h8765_4321; s.ccs = 16'h001B; send(s); idle(1);
        // R14: gates and TSS ignore DPL, present, stack and offset
        s = base("R14 callgate"); s.s = 1'b0; s.typ = 4'hC; s.pres = 1'b0; s.sfree = 0; send(s);
        s = base("R14 taskgate"); s.s = 1'b0; s.typ = 4'h5; s.dpl = 2'd3; send(s);
        s = base("R14 tss"); s.s = 1'b0; s.typ = 4'h9; s.off = 32'hFFFF_FFFF; send(s);
        idle(1);
        // R13 R12: trap only on success
        s = base("R13 trap"); s.trap = 1'b1; send(s); idle(1);
        s = base("R12 trap fault"); s.trap = 1'b1; s.pres = 1'b0; send(s); idle(1);
        idle(4);
        chk("R1", "scoreboard drained", 64'(q.size()), 64'd0);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (20000) @(posedge clk);
                errors++;
                $display("FAIL R1 watchdog actual hung expected done");
            end
        join_any
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule